// File: doc/BRIEF.md
# Motion Wake and Sleep Detector

This block watches signed three-axis acceleration samples and runs two detectors in parallel. The wake detector reports sustained activity above a threshold window. The sleep detector reports sustained stillness inside that window. Each detector advances only on its own sample-rate strobe, so the two can run at different rates. A debounce counter qualifies each detector's condition: a programmed count of N gives a delay of N sample periods at that detector's rate.

Per-axis, per-direction masks select which excursions count. A counter mode chooses whether a lapse in the condition clears the counter or steps it back by one. A pulse-reject mode discards one-sided spikes on axes that watch both directions. The block only raises interrupt flags and a wake source vector. It never changes its own configuration inputs. Each flag holds until its clear pulse arrives.

Top module: `motion_wake_sleep`

## Requirements
- R1: When a detector's enable is low, its interrupt flag is low and its counter is zero in the cycle after; the wake source vector is zero while wake is disabled.
- R2: Axis a (x=0, y=1, z=2) occupies accel_i[16a+15:16a] as two's complement. Direction bit 2a means positive, with the sample strictly above thr_i. Direction bit 2a+1 means negative, with the sample strictly below -thr_i. A direction takes part only if its bit in dir_mask_i is 1.
- R3: When the qualifying condition is absent on a detector's strobe, ctr_mode_i=0 clears the counter and ctr_mode_i=1 decrements it, saturating at zero.
- R4: The wake counter and flag change only on cycles with wake_stb_i, and the sleep counter and flag only on cycles with sleep_stb_i. Enable and clear are the exceptions.
- R5: On a strobe with the condition present, the event fires when the counter is already at or above the programmed count; otherwise the counter increments. A count of 0 fires on the first qualifying sample. The flag is visible one cycle after that strobe.
- R6: A flag stays set until its clear input is high. While set, its counter holds at zero. A clear zeroes both the flag and the counter and takes priority over a strobe in the same cycle.
- R7: When the wake event fires, wake_src_o latches the direction bits (R2 encoding) that qualified on that sample. It returns to zero when the wake flag clears.
- R8: The wake condition is any qualifying direction bit. The sleep condition is no qualifying direction bit.
- R9: With pulse_rej_i=1 on an axis whose two direction bits are both enabled, an excursion on that axis qualifies only if the run of consecutive wake samples with excursions on that axis has shown both a positive and a negative excursion. A wake sample with no excursion on that axis ends the run.
- R10: Pulse rejection has no effect on an axis that has only one direction enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_stb_i | input | 1 | Wake sample-period strobe |
| sleep_stb_i | input | 1 | Sleep sample-period strobe |
| accel_i | input | 48 | Three signed 16-bit axis samples, x in the low bits |
| thr_i | input | 15 | Threshold window half-width, unsigned |
| dir_mask_i | input | 6 | Direction enables, bit 2a positive and bit 2a+1 negative for axis a |
| wake_en_i | input | 1 | Wake detector enable |
| sleep_en_i | input | 1 | Sleep detector enable |
| ctr_mode_i | input | 1 | Lapse behaviour: 0 clear, 1 decrement |
| pulse_rej_i | input | 1 | Pulse-reject enable |
| wake_cnt_i | input | 8 | Wake delay in wake sample periods |
| sleep_cnt_i | input | 8 | Sleep delay in sleep sample periods |
| wake_clr_i | input | 1 | Clears the wake flag and its source vector |
| sleep_clr_i | input | 1 | Clears the sleep flag |
| wake_irq_o | output | 1 | Wake interrupt flag |
| sleep_irq_o | output | 1 | Sleep interrupt flag |
| wake_src_o | output | 6 | Direction bits that caused the last wake event |

## Verification
The assertions take two things for granted. First, thr_i is non-negative, so the positive and negative tests on one axis never pass together. Second, the configuration can change on any cycle, and a lowered programmed count simply fires on the next qualifying strobe. The stimulus keeps samples in a band around a random threshold so that hits and quiet samples both occur. It holds the programmed counts small so that events happen often. It raises the clears, the enables and the pulse-reject mode at random, and the directed cases cover zero counts, alternating excursions and single-direction masks.

// File: rtl/mws_pkg.sv
package mws_pkg;
  typedef enum logic {
    CTR_CLEAR = 1'b0,
    CTR_DECR  = 1'b1
  } ctr_mode_e;
endpackage

// File: rtl/mws_axis_cmp.sv
module mws_axis_cmp #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] sample_i,
  input  logic [DW-2:0] thr_i,
  input  logic          pos_en_i,
  input  logic          neg_en_i,
  output logic          pos_o,
  output logic          neg_o
);
  localparam int EW = DW + 1;

  logic signed [EW-1:0] s_ext, t_ext, t_neg;

  assign s_ext = {sample_i[DW-1], sample_i};
  assign t_ext = {2'b00, thr_i};
  assign t_neg = -t_ext;

  assign pos_o = pos_en_i && (s_ext > t_ext);
  assign neg_o = neg_en_i && (s_ext < t_neg);

  always_comb begin
    AST_DIR_EXCL: assert (!(pos_o && neg_o)); // R2
  end
endmodule

// File: rtl/mws_pulse_gate.sv
module mws_pulse_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic pr_en_i,
  input  logic pos_i,
  input  logic neg_i,
  output logic pos_o,
  output logic neg_o
);
  logic seen_p_q, seen_n_q;
  logic any, qual;

  assign any  = pos_i || neg_i;
  assign qual = any && (seen_p_q || pos_i) && (seen_n_q || neg_i);

  assign pos_o = pr_en_i ? (pos_i && qual) : pos_i;
  assign neg_o = pr_en_i ? (neg_i && qual) : neg_i;

  // run of consecutive excursions; a quiet sample ends it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_p_q <= 1'b0;
      seen_n_q <= 1'b0;
    end else if (stb_i) begin
      if (!any) begin
        seen_p_q <= 1'b0;
        seen_n_q <= 1'b0;
      end else begin
        seen_p_q <= seen_p_q || pos_i;
        seen_n_q <= seen_n_q || neg_i;
      end
    end
  end

  AST_RUN_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !any) |=> (!seen_p_q && !seen_n_q)); // R9
  AST_PASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pr_en_i |-> (pos_o == pos_i && neg_o == neg_i)); // R10
endmodule

// File: rtl/mws_debounce.sv
module mws_debounce
  import mws_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          stb_i,
  input  logic          cond_i,
  input  ctr_mode_e     mode_i,
  input  logic [CW-1:0] target_i,
  input  logic          clr_i,
  output logic          irq_o,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          irq_q, irq_d;
  logic          at_target;

  assign at_target = (cnt_q >= target_i);
  assign fire_o    = en_i && !clr_i && stb_i && !irq_q && cond_i && at_target;
  assign irq_o     = irq_q;

  always_comb begin
    cnt_d = cnt_q;
    irq_d = irq_q;
    if (!en_i || clr_i) begin
      cnt_d = '0;
      irq_d = 1'b0;
    end else if (stb_i && !irq_q) begin
      if (cond_i) begin
        if (at_target) begin
          irq_d = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (mode_i == CTR_DECR) begin
        cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!irq_q && cnt_q == '0)); // R1
  AST_DECR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && stb_i && !irq_q && !cond_i && mode_i == CTR_DECR && cnt_q != '0)
    |=> cnt_q == $past(cnt_q) - 1'b1); // R3
  AST_NO_STB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !stb_i) |=> ($stable(irq_q) && $stable(cnt_q))); // R4
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_i) |=> (!irq_q && cnt_q == '0)); // R6
  AST_HELD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> cnt_q == '0); // R6
endmodule

// File: rtl/motion_wake_sleep.sv
module motion_wake_sleep
  import mws_pkg::*;
#(
  parameter int DW  = 16,
  parameter int CW  = 8,
  parameter int NAX = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wake_stb_i,
  input  logic               sleep_stb_i,
  input  logic [NAX*DW-1:0]  accel_i,
  input  logic [DW-2:0]      thr_i,
  input  logic [2*NAX-1:0]   dir_mask_i,
  input  logic               wake_en_i,
  input  logic               sleep_en_i,
  input  logic               ctr_mode_i,
  input  logic               pulse_rej_i,
  input  logic [CW-1:0]      wake_cnt_i,
  input  logic [CW-1:0]      sleep_cnt_i,
  input  logic               wake_clr_i,
  input  logic               sleep_clr_i,
  output logic               wake_irq_o,
  output logic               sleep_irq_o,
  output logic [2*NAX-1:0]   wake_src_o
);
  localparam int NDIR = 2 * NAX;

  logic [NDIR-1:0] raw_hit, eff_hit, src_q;
  logic            wake_fire, sleep_fire;
  ctr_mode_e       mode;

  assign mode = ctr_mode_e'(ctr_mode_i);

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    logic pr_en;
    assign pr_en = pulse_rej_i && dir_mask_i[2*a] && dir_mask_i[2*a+1];

    mws_axis_cmp #(.DW(DW)) u_cmp (
      .sample_i (accel_i[a*DW +: DW]),
      .thr_i    (thr_i),
      .pos_en_i (dir_mask_i[2*a]),
      .neg_en_i (dir_mask_i[2*a+1]),
      .pos_o    (raw_hit[2*a]),
      .neg_o    (raw_hit[2*a+1])
    );

    mws_pulse_gate u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .stb_i   (wake_stb_i),
      .pr_en_i (pr_en),
      .pos_i   (raw_hit[2*a]),
      .neg_i   (raw_hit[2*a+1]),
      .pos_o   (eff_hit[2*a]),
      .neg_o   (eff_hit[2*a+1])
    );
  end

  mws_debounce #(.CW(CW)) u_wake (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (wake_en_i),
    .stb_i    (wake_stb_i),
    .cond_i   (|eff_hit),
    .mode_i   (mode),
    .target_i (wake_cnt_i),
    .clr_i    (wake_clr_i),
    .irq_o    (wake_irq_o),
    .fire_o   (wake_fire)
  );

  mws_debounce #(.CW(CW)) u_sleep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (sleep_en_i),
    .stb_i    (sleep_stb_i),
    .cond_i   (~|eff_hit),
    .mode_i   (mode),
    .target_i (sleep_cnt_i),
    .clr_i    (sleep_clr_i),
    .irq_o    (sleep_irq_o),
    .fire_o   (sleep_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      src_q <= '0;
    else if (!wake_en_i || wake_clr_i) src_q <= '0;
    else if (wake_fire)               src_q <= eff_hit;
  end

  assign wake_src_o = src_q;

  AST_SRC_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_irq_o) |-> (wake_src_o != '0)); // R7
  AST_SRC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_irq_o |-> (wake_src_o == '0)); // R7
  AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wake_fire && sleep_fire)); // R8
endmodule

// File: tb/motion_wake_sleep_tb_top.sv
module motion_wake_sleep_tb_top;
  localparam int DW  = 16;
  localparam int CW  = 8;
  localparam int NAX = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic              wake_stb, sleep_stb, wake_en, sleep_en, ctr_mode, pulse_rej;
  logic              wake_clr, sleep_clr;
  logic [NAX*DW-1:0] accel;
  logic [DW-2:0]     thr;
  logic [5:0]        dir_mask;
  logic [CW-1:0]     wake_cnt, sleep_cnt;
  logic              wake_irq, sleep_irq;
  logic [5:0]        wake_src;

  motion_wake_sleep #(.DW(DW), .CW(CW), .NAX(NAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wake_stb_i(wake_stb), .sleep_stb_i(sleep_stb),
    .accel_i(accel), .thr_i(thr), .dir_mask_i(dir_mask), .wake_en_i(wake_en),
    .sleep_en_i(sleep_en), .ctr_mode_i(ctr_mode), .pulse_rej_i(pulse_rej),
    .wake_cnt_i(wake_cnt), .sleep_cnt_i(sleep_cnt), .wake_clr_i(wake_clr),
    .sleep_clr_i(sleep_clr), .wake_irq_o(wake_irq), .sleep_irq_o(sleep_irq),
    .wake_src_o(wake_src)
  );

  int vecs = 0;
  int errs = 0;

  logic [CW-1:0] m_wc = '0, m_sc = '0;
  logic          m_wi = 1'b0, m_si = 1'b0;
  logic [5:0]    m_src = '0;
  logic [2:0]    m_sp = '0, m_sn = '0;

  function automatic logic [5:0] raw_hits(input logic [NAX*DW-1:0] a,
                                          input logic [DW-2:0] t, input logic [5:0] m);
    logic [5:0] h;
    h = '0;
    for (int ax = 0; ax < NAX; ax++) begin
      logic signed [DW:0] s, te;
      s  = {a[ax*DW+DW-1], a[ax*DW +: DW]};
      te = {2'b00, t};
      h[2*ax]   = m[2*ax]   && (s > te);
      h[2*ax+1] = m[2*ax+1] && (s < -te);
    end
    return h;
  endfunction

  task automatic dbn(inout logic [CW-1:0] c, inout logic irq, output logic fire,
                     input logic en, input logic stb, input logic cond,
                     input logic [CW-1:0] tgt, input logic clr);
    fire = 1'b0;
    if (!en || clr) begin
      c = '0; irq = 1'b0;
    end else if (stb && !irq) begin
      if (cond) begin
        if (c >= tgt) begin irq = 1'b1; c = '0; fire = 1'b1; end
        else c = c + 1'b1;
      end else if (ctr_mode) c = (c == '0) ? '0 : c - 1'b1;
      else c = '0;
    end
  endtask

  task automatic model();
    logic [5:0] h, e;
    logic wf, sf;
    h = raw_hits(accel, thr, dir_mask);
    e = h;
    for (int ax = 0; ax < NAX; ax++) begin
      logic p, n, q;
      p = h[2*ax]; n = h[2*ax+1];
      q = (p || n) && (m_sp[ax] || p) && (m_sn[ax] || n);
      if (pulse_rej && dir_mask[2*ax] && dir_mask[2*ax+1]) begin
        e[2*ax] = p && q; e[2*ax+1] = n && q;
      end
    end
    dbn(m_wc, m_wi, wf, wake_en, wake_stb, |e, wake_cnt, wake_clr);
    dbn(m_sc, m_si, sf, sleep_en, sleep_stb, ~|e, sleep_cnt, sleep_clr);
    if (!wake_en || wake_clr) m_src = '0;
    else if (wf) m_src = e;
    if (wake_stb)
      for (int ax = 0; ax < NAX; ax++) begin
        if (!(h[2*ax] || h[2*ax+1])) begin m_sp[ax] = 1'b0; m_sn[ax] = 1'b0; end
        else begin m_sp[ax] |= h[2*ax]; m_sn[ax] |= h[2*ax+1]; end
      end
  endtask

  task automatic chk(input string tag, input string what, input logic [5:0] act, input logic [5:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "wake_irq", {5'b0, wake_irq}, {5'b0, m_wi});
    chk(tag, "sleep_irq", {5'b0, sleep_irq}, {5'b0, m_si});
    chk(tag, "wake_src", wake_src, m_src);
  endtask

  task automatic set_axes(input int x, input int y, input int z);
    accel = {16'(z), 16'(y), 16'(x)};
  endtask

  task automatic idle_cfg();
    wake_stb = 0; sleep_stb = 0; wake_en = 1; sleep_en = 1; ctr_mode = 0; pulse_rej = 0;
    wake_clr = 0; sleep_clr = 0; thr = 15'd100; dir_mask = 6'h3F;
    wake_cnt = 8'd2; sleep_cnt = 8'd3; set_axes(0, 0, 0);
  endtask

  task automatic clear_all();
    wake_clr = 1; sleep_clr = 1; step("R6");
    wake_clr = 0; sleep_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    idle_cfg();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "wake_irq", {5'b0, wake_irq}, 6'd0);
    chk("R1", "sleep_irq", {5'b0, sleep_irq}, 6'd0);
    chk("R1", "wake_src", wake_src, 6'd0);

    // R5/R7: x positive, count 2 fires on third strobe
    sleep_en = 0; set_axes(200, 0, 0); wake_stb = 1;
    repeat (4) step("R5");
    chk("R7", "src x+", wake_src, 6'b000001);
    // R4: no strobe, flag holds
    wake_stb = 0; repeat (3) step("R4");
    clear_all();
    // R6: clear with strobe same cycle
    wake_cnt = 0; wake_stb = 1; wake_clr = 1; step("R6");
    wake_clr = 0; step("R5");
    chk("R5", "zero count fires", {5'b0, wake_irq}, 6'd1);
    clear_all();
    // R2: masks and strict threshold
    dir_mask = 6'b001000; wake_cnt = 1;
    set_axes(200, 100, 0); repeat (2) step("R2");
    set_axes(-100, -101, 0); repeat (2) step("R2");
    chk("R2", "src y-", wake_src, 6'b001000);
    clear_all();
    // R3: lapse modes
    dir_mask = 6'h3F; wake_cnt = 3;
    for (int md = 0; md < 2; md++) begin
      ctr_mode = md[0];
      set_axes(0, 0, 300); repeat (2) step("R3");
      set_axes(0, 0, 0); step("R3");
      set_axes(0, 0, 300); repeat (3) step("R3");
      clear_all();
    end
    // R9: single-sided pulses rejected, alternating counted
    pulse_rej = 1; wake_cnt = 1; ctr_mode = 0;
    for (int i = 0; i < 6; i++) begin
      set_axes((i % 2) ? 0 : 250, 0, 0); step("R9");
    end
    chk("R9", "one-sided", {5'b0, wake_irq}, 6'd0);
    for (int i = 0; i < 4; i++) begin
      set_axes((i % 2) ? -250 : 250, 0, 0); step("R9");
    end
    clear_all();
    // R10: single direction enabled ignores pulse reject
    dir_mask = 6'b000001; wake_cnt = 0; set_axes(250, 0, 0); step("R10");
    chk("R10", "fires", {5'b0, wake_irq}, 6'd1);
    clear_all();
    pulse_rej = 0; dir_mask = 6'h3F;
    // R8: sleep on quiet data
    sleep_en = 1; wake_stb = 0; sleep_stb = 1; set_axes(10, -20, 5);
    repeat (5) step("R8");
    chk("R8", "sleep set", {5'b0, sleep_irq}, 6'd1);
    clear_all();
    // R1: disabled wake never fires
    wake_en = 0; wake_stb = 1; wake_cnt = 0; set_axes(500, 0, 0);
    repeat (3) step("R1");
    wake_en = 1;

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      wake_stb  = ($urandom_range(0, 2) != 0);
      sleep_stb = ($urandom_range(0, 2) != 0);
      wake_en   = ($urandom_range(0, 15) != 0);
      sleep_en  = ($urandom_range(0, 15) != 0);
      wake_clr  = ($urandom_range(0, 11) == 0);
      sleep_clr = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 19) == 0) begin
        ctr_mode  = 1'($urandom_range(0, 1));
        pulse_rej = 1'($urandom_range(0, 1));
        dir_mask  = 6'($urandom_range(0, 63));
        thr       = 15'($urandom_range(0, 300));
        wake_cnt  = 8'($urandom_range(0, 4));
        sleep_cnt = 8'($urandom_range(0, 4));
      end
      if ($urandom_range(0, 1) == 0) set_axes(0, 0, 0);
      else set_axes($urandom_range(0, 800) - 400, $urandom_range(0, 800) - 400,
                    $urandom_range(0, 800) - 400);
      step("R3 R5 R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule